// File: doc/BRIEF.md
# Channel Interrupt Status and Bus-Error Address Capture

This block gathers the two interrupt causes of a storage-channel host adapter: an attention event from the attached drive and a bus fault seen while the adapter moves data by DMA. Each cause owns one bit in a pending register. A pending bit stays set until software writes a one to it. A separate enable mask, changed through a set view and a clear view, decides which pending bits drive the single level-sensitive interrupt line.

When a bus fault is recorded and its pending bit was not already set, the 64-bit faulting address is latched. Software then reads it back as two 32-bit words. Later faults do not touch the latched address while the fault bit stays pending, so the first failure is the one preserved.

Software reaches the block through a word-aligned register port with one write strobe and one read strobe. The port has no back-pressure: every strobe is taken in the cycle it is presented, and read data returns one cycle later with a valid flag. Both event inputs are single-cycle pulses.

Top module: `chan_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_o` and `reg_rvalid_o` are low. All registers read as zero until an event or a write changes them.
- R2: A pulse on `dev_evt_i` sets pending bit 0 and a pulse on `buserr_evt_i` sets pending bit 1, whatever the enable mask holds. The pending word reads at byte offset 0x0C, with bits 31..2 zero.
- R3: Writing to byte offset 0x0C clears each pending bit whose write-data bit is 1 and leaves pending bits written with 0 unchanged.
- R4: If an event arrives in the same cycle as a write that clears its pending bit, the bit stays set.
- R5: Writing to byte offset 0x14 sets each enable bit whose data bit is 1. Writing to byte offset 0x1C clears each enable bit whose data bit is 1. Reads at either offset return the enable mask in bits 1..0.
- R6: `irq_o` is high exactly when some bit is both pending and enabled. It follows the register state in the cycle after the event or write that changes it.
- R7: A bus-error pulse that arrives while pending bit 1 is clear latches `buserr_addr_i`. Bits 31..0 then read at byte offset 0x00 and bits 63..32 at byte offset 0x04.
- R8: A bus-error pulse that arrives while pending bit 1 is set leaves the latched address unchanged. After bit 1 is cleared, the next pulse latches again.
- R9: Reads of any other offset, including one not aligned to a word, return zero. Writes to such offsets change no register.
- R10: A read strobe gives `reg_rvalid_o` high in the next cycle, with the value the register held before that edge. With no read strobe, `reg_rvalid_o` is low and `reg_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_evt_i | input | 1 | Drive attention pulse |
| buserr_evt_i | input | 1 | DMA bus-fault pulse |
| buserr_addr_i | input | 64 | Faulting address, valid with the fault pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte address of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after `reg_rd_i` |
| reg_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The properties assume that each event input is a clean single-cycle pulse and that the port inputs are known whenever reset is released. A write and a read may share a cycle, because they then use the same address. The stimulus drives every input on the falling edge, so it is stable at each rising edge. It returns events to zero after a single cycle, including in the pseudo-random section, where events, writes, reads and unaligned addresses are mixed freely. Collisions between an event and its own clear are placed deliberately, since the property for that case only holds if the pulse is actually present in that cycle.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int unsigned NSRC     = 2;
  localparam int unsigned SRC_DEV  = 0;
  localparam int unsigned SRC_BERR = 1;

  // word indexes; byte offset is index * 4
  localparam int unsigned WIX_ERR_LO = 0;
  localparam int unsigned WIX_ERR_HI = 1;
  localparam int unsigned WIX_PEND   = 3;
  localparam int unsigned WIX_ENSET  = 5;
  localparam int unsigned WIX_ENCLR  = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ERR_LO, SEL_ERR_HI, SEL_PEND, SEL_ENSET, SEL_ENCLR
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic aligned, input int unsigned widx);
    reg_sel_e s;
    s = SEL_NONE;
    if (aligned) begin
      case (widx)
        WIX_ERR_LO: s = SEL_ERR_LO;
        WIX_ERR_HI: s = SEL_ERR_HI;
        WIX_PEND:   s = SEL_PEND;
        WIX_ENSET:  s = SEL_ENSET;
        WIX_ENCLR:  s = SEL_ENCLR;
        default:    s = SEL_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic w1c_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic pend_o,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      // a new event outranks a clear in the same cycle
      pend_o <= evt_i | (pend_o & ~w1c_i);
      if (en_set_i)      en_o <= 1'b1;
      else if (en_clr_i) en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/err_addr_latch.sv
module err_addr_latch #(
  parameter int unsigned AW = 64,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic          armed_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o
);
  localparam int unsigned HI_W = AW - DW;

  logic [AW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              held_q <= '0;
    else if (evt_i && armed_i) held_q <= addr_i;
  end

  assign lo_o = held_q[DW-1:0];

  generate
    if (HI_W >= DW) begin : g_hi_full
      assign hi_o = held_q[DW +: DW];
    end else begin : g_hi_pad
      assign hi_o = {{(DW-HI_W){1'b0}}, held_q[AW-1:DW]};
    end
  endgenerate
endmodule

// File: rtl/reg_read_port.sv
module reg_read_port
  import chan_irq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  reg_sel_e      sel_i,
  input  logic [NS-1:0] pend_i,
  input  logic [NS-1:0] en_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mux_w;

  always_comb begin
    mux_w = '0;
    unique case (sel_i)
      SEL_ERR_LO:           mux_w = lo_i;
      SEL_ERR_HI:           mux_w = hi_i;
      SEL_PEND:             mux_w[NS-1:0] = pend_i;
      SEL_ENSET, SEL_ENCLR: mux_w[NS-1:0] = en_i;
      default:              mux_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? mux_w : '0;
    end
  end
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chan_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ERR_AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_evt_i,
  input  logic              buserr_evt_i,
  input  logic [ERR_AW-1:0] buserr_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              reg_rvalid_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned WIX_W = ADDR_W - 2;

  reg_sel_e          sel_w;
  logic [NSRC-1:0]   evt_w;
  logic [NSRC-1:0]   pend_w;
  logic [NSRC-1:0]   en_w;
  logic [DATA_W-1:0] err_lo_w;
  logic [DATA_W-1:0] err_hi_w;
  logic [WIX_W-1:0]  wix_w;

  assign wix_w = reg_addr_i[ADDR_W-1:2];
  assign sel_w = decode_word(reg_addr_i[1:0] == 2'b00, int'(wix_w));

  assign evt_w[SRC_DEV]  = dev_evt_i;
  assign evt_w[SRC_BERR] = buserr_evt_i;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      irq_src_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_w[g]),
        .w1c_i    (reg_wr_i && (sel_w == SEL_PEND)  && reg_wdata_i[g]),
        .en_set_i (reg_wr_i && (sel_w == SEL_ENSET) && reg_wdata_i[g]),
        .en_clr_i (reg_wr_i && (sel_w == SEL_ENCLR) && reg_wdata_i[g]),
        .pend_o   (pend_w[g]),
        .en_o     (en_w[g])
      );
    end
  endgenerate

  err_addr_latch #(.AW(ERR_AW), .DW(DATA_W)) u_errcap (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (buserr_evt_i),
    .armed_i (~pend_w[SRC_BERR]),
    .addr_i  (buserr_addr_i),
    .lo_o    (err_lo_w),
    .hi_o    (err_hi_w)
  );

  reg_read_port #(.DW(DATA_W), .NS(NSRC)) u_rdport (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (reg_rd_i),
    .sel_i    (sel_w),
    .pend_i   (pend_w),
    .en_i     (en_w),
    .lo_i     (err_lo_w),
    .hi_i     (err_hi_w),
    .rvalid_o (reg_rvalid_o),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o = |(pend_w & en_w);
endmodule

// File: rtl/chan_irq_ctrl_chk.sv
module chan_irq_ctrl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_evt,
  input logic              buserr_evt,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rvalid,
  input logic              irq,
  input logic [1:0]        pend,
  input logic [1:0]        en,
  input logic [DATA_W-1:0] err_lo,
  input logic [DATA_W-1:0] err_hi
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && !rvalid));

  // R2
  dev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_evt |=> pend[0]);

  // R4
  berr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buserr_evt && reg_wr && reg_addr == 8'h0C && reg_wdata[1]) |=> pend[1]);

  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h0C && reg_wdata[0] && !dev_evt) |=> !pend[0]);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && buserr_evt) |=> ($stable(err_lo) && $stable(err_hi)));

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != 8'h14 && reg_addr != 8'h1C) |=> $stable(en));

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rvalid);

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b00) |-> !irq);
endmodule

bind chan_irq_ctrl chan_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_evt    (dev_evt_i),
  .buserr_evt (buserr_evt_i),
  .reg_wr     (reg_wr_i),
  .reg_rd     (reg_rd_i),
  .reg_addr   (reg_addr_i),
  .reg_wdata  (reg_wdata_i),
  .rvalid     (reg_rvalid_o),
  .irq        (irq_o),
  .pend       (pend_w),
  .en         (en_w),
  .err_lo     (err_lo_w),
  .err_hi     (err_hi_w)
);

// File: tb/sim_chan_irq_ctrl.sv
`timescale 1ns/100ps
module sim_chan_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dev_evt = 1'b0, berr_evt = 1'b0;
  logic [63:0] berr_addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid, irq;
  logic [31:0] rdata;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  bit [1:0]  m_pend = '0, m_en = '0;
  bit [31:0] m_lo = '0, m_hi = '0, m_rdata = '0;
  bit        m_rvalid = 1'b0;

  always #2.5 clk = ~clk;

  chan_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dev_evt_i(dev_evt), .buserr_evt_i(berr_evt),
    .buserr_addr_i(berr_addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rvalid_o(rvalid), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic bit [31:0] model_read(input bit [7:0] a);
    if (a == 8'h00) return m_lo;
    if (a == 8'h04) return m_hi;
    if (a == 8'h0C) return {30'd0, m_pend};
    if (a == 8'h14 || a == 8'h1C) return {30'd0, m_en};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_lo = '0; m_hi = '0; m_rvalid = 0; m_rdata = '0;
    end else begin
      bit [1:0] np;
      m_rvalid = rd;
      m_rdata  = rd ? model_read(addr) : 32'd0;
      if (berr_evt && !m_pend[1]) begin
        m_lo = berr_addr[31:0];
        m_hi = berr_addr[63:32];
      end
      np = m_pend;
      if (wr && addr == 8'h0C) np = np & ~wdata[1:0];
      if (dev_evt)  np[0] = 1'b1;
      if (berr_evt) np[1] = 1'b1;
      m_pend = np;
      if (wr && addr == 8'h14) m_en = m_en | wdata[1:0];
      if (wr && addr == 8'h1C) m_en = m_en & ~wdata[1:0];
    end
  end

  // compare away from the rising edge; R6 on irq, R10 plus phase tag on reads
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (irq !== (|(m_pend & m_en))) begin
        n_bad++;
        $display("FAIL R6/%s irq_o got %0b exp %0b at %0t", cur_req, irq, |(m_pend & m_en), $time);
      end
      n_cmp++;
      if (rvalid !== m_rvalid || rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL R10/%s read got v=%0b d=%h exp v=%0b d=%h at %0t",
                 cur_req, rvalid, rdata, m_rvalid, m_rdata, $time);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_wr(input bit [7:0] a, input bit [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = '0;
  endtask

  task automatic do_rd(input bit [7:0] a);
    rd = 1; addr = a;
    @(negedge clk); rd = 0;
    @(negedge clk);
  endtask

  task automatic dev_pulse();
    dev_evt = 1; @(negedge clk); dev_evt = 0;
  endtask

  task automatic err_pulse(input bit [63:0] a);
    berr_evt = 1; berr_addr = a; @(negedge clk); berr_evt = 0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, run did not end");
    summary();
  end

  initial begin
    bit [15:0] lfsr;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    // R1: reset state
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    for (int a = 0; a < 32; a += 4) do_rd(8'(a));

    // R2: events set pending bits regardless of enable
    cur_req = "R2";
    dev_pulse(); do_rd(8'h0C);
    // R7: first fault latches address
    cur_req = "R7";
    err_pulse(64'h1234_5678_9ABC_DEF0);
    do_rd(8'h0C); do_rd(8'h00); do_rd(8'h04);
    // R8: later fault keeps the first address
    cur_req = "R8";
    err_pulse(64'hFFFF_0000_AAAA_5555);
    do_rd(8'h00); do_rd(8'h04);
    do_wr(8'h0C, 32'h2); do_rd(8'h0C);
    err_pulse(64'h0000_0001_0000_0002);
    do_rd(8'h00); do_rd(8'h04);

    // R3: write-one-to-clear, zeros ignored
    cur_req = "R3";
    do_wr(8'h0C, 32'h0); do_rd(8'h0C);
    do_wr(8'h0C, 32'h1); do_rd(8'h0C);
    do_wr(8'h0C, 32'h3); do_rd(8'h0C);

    // R5 / R6: enable set and clear views drive irq_o
    cur_req = "R5";
    do_wr(8'h14, 32'h3); do_rd(8'h14); do_rd(8'h1C);
    cur_req = "R6";
    dev_pulse(); idle(2);
    do_wr(8'h1C, 32'h1); idle(1);
    err_pulse(64'h42); idle(2);
    do_wr(8'h0C, 32'h3); idle(1);
    cur_req = "R5";
    do_rd(8'h1C);
    do_wr(8'h14, 32'h1);

    // R4: event and clear in the same cycle
    cur_req = "R4";
    dev_evt = 1; wr = 1; addr = 8'h0C; wdata = 32'h1;
    @(negedge clk); dev_evt = 0; wr = 0;
    do_rd(8'h0C);
    berr_evt = 1; berr_addr = 64'h77; wr = 1; addr = 8'h0C; wdata = 32'h2;
    @(negedge clk); berr_evt = 0; wr = 0;
    do_rd(8'h0C); do_rd(8'h00);

    // R9: stray offsets
    cur_req = "R9";
    do_wr(8'h08, 32'hFFFF_FFFF); do_wr(8'h10, 32'h3); do_wr(8'h15, 32'h3);
    do_wr(8'h1E, 32'h3); do_wr(8'h0D, 32'h3);
    do_rd(8'h08); do_rd(8'h10); do_rd(8'h16); do_rd(8'h1C); do_rd(8'h0C); do_rd(8'h20);

    // R10: read and write in one cycle returns the old value
    cur_req = "R10";
    rd = 1; wr = 1; addr = 8'h14; wdata = 32'h2;
    @(negedge clk); rd = 0; wr = 0;
    do_rd(8'h14);

    // mixed traffic
    cur_req = "mix";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dev_evt   = (lfsr[2:0] == 3'd5);
      berr_evt  = (lfsr[5:3] == 3'd2);
      berr_addr = {lfsr, ~lfsr, lfsr ^ 16'h5A5A, 16'(i)};
      wr        = lfsr[7] & lfsr[8];
      rd        = lfsr[9];
      addr      = (lfsr[15:13] == 3'd6) ? 8'h02 : {3'd0, lfsr[12:10], 2'b00};
      wdata     = {30'd0, lfsr[1:0]};
      @(negedge clk);
    end
    dev_evt = 0; berr_evt = 0; wr = 0; rd = 0;
    idle(3);
    summary();
  end
endmodule